// File: doc/BRIEF.md
# Per-Crossing Trigger Frame Builder

This block gathers one 16-bit trigger-primitive word from each of several front-end module links and turns them into a single fixed-slot frame for every beam crossing. A serial transmitter further down the chain serializes the frame. Each link presents a parallel word with a valid flag. A one-cycle crossing strobe freezes the link words, their valid flags and the running crossing number. The frame is then sent out one word per clock, and the first word is marked with a frame-start flag.

The frame always has the same layout. It opens with a fixed alignment marker and then carries the crossing number. A bitmap word follows, telling which links had data. One payload slot comes after that for each link, in ascending link index. A link without data still occupies its slot, and that slot is sent as zeros. If the next strobe arrives before the current frame has been fully sent, the rest of that frame is dropped, the new frame starts at once and a one-cycle overflow flag is raised.

Top module: `trig_frame_builder`

## Requirements
- R1: While reset is low and afterwards until the first strobe, `frm_valid_o`, `frm_sof_o` and `overflow_o` are low and `frm_word_o` is zero. The first frame after reset carries crossing number 0.
- R2: The cycle after a clock edge that samples `xing_i` high, the block presents word 0 of a new frame with `frm_sof_o` and `frm_valid_o` high. Words 1 to 2+N_LINKS follow on consecutive cycles with `frm_sof_o` low. `frm_valid_o` then drops and `frm_word_o` returns to zero.
- R3: Word 0 of every frame equals the marker parameter `ALIGN_WORD`, which defaults to 16'hBC1C.
- R4: Word 1 is the crossing number. It advances by one with each strobe and wraps from 16'hFFFF to 16'h0000.
- R5: Word 2 is the valid bitmap. Bit i is link i's valid flag at the strobe, and the bits above N_LINKS-1 are zero.
- R6: Word 3+i carries link i's data word as sampled at the strobe, for i from 0 to N_LINKS-1. Link i's data sits in bits [16*i+15:16*i] of `lnk_data_i`.
- R7: A slot whose link was not valid at the strobe is sent as 16'h0000, whatever that link's data bits held.
- R8: A strobe that arrives while an earlier frame still has words left to send cuts that frame short. The next cycle shows word 0 of the new frame, and `overflow_o` is high for that one cycle only.
- R9: A strobe sampled on the same edge that ends the last word of a frame starts the next frame with no gap, and `overflow_o` stays low.
- R10: Changes on `lnk_data_i` and `lnk_valid_i` between strobes do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xing_i | input | 1 | Beam-crossing strobe, one cycle per crossing |
| lnk_data_i | input | N_LINKS*16 | Link words, link i in bits [16*i+15:16*i] |
| lnk_valid_i | input | N_LINKS | Per-link valid flags |
| frm_word_o | output | 16 | Frame word stream |
| frm_valid_o | output | 1 | Frame word present |
| frm_sof_o | output | 1 | First word of a frame |
| overflow_o | output | 1 | One-cycle pulse when a frame was cut short |

## Verification
The bench aims at the places where the slot layout and the counter are easy to get wrong. One case fills invalid links with nonzero data: a design that forgets to zero those slots would leak stale words into the frame. Another case scrambles the link inputs while a frame is going out, which exposes a design that reads live inputs instead of a snapshot. The bench lines up one strobe exactly on the last word, where a design with an off-by-one end test would either raise a false overflow or lose the first word of the next frame. It also fires a strobe in mid-frame, which must truncate the frame and pulse overflow. Finally, a long train of strobes takes the crossing number through 16'hFFFF to 0, and a design with a counter that is too narrow or saturates would give the wrong number there.

// File: rtl/trig_frame_builder.sv
module trig_frame_builder #(
  parameter int          N_LINKS    = 6,
  parameter int          WORD_W     = 16,
  parameter logic [15:0] ALIGN_WORD = 16'hBC1C
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xing_i,
  input  logic [N_LINKS*WORD_W-1:0]  lnk_data_i,
  input  logic [N_LINKS-1:0]         lnk_valid_i,
  output logic [WORD_W-1:0]          frm_word_o,
  output logic                       frm_valid_o,
  output logic                       frm_sof_o,
  output logic                       overflow_o
);

  localparam int HDR_WORDS = 3;
  localparam int FRAME_LEN = HDR_WORDS + N_LINKS;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [WORD_W-1:0]                   xcnt_q, xnum_q;
  logic [N_LINKS-1:0]                  vmap_q;
  logic [N_LINKS-1:0][WORD_W-1:0]      slot_q;
  logic [IDX_W-1:0]                    idx_q;
  logic                                busy_q, ovf_q;
  logic [WORD_W-1:0]                   word_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q <= '0;
      xnum_q <= '0;
      vmap_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (xing_i) begin
        xnum_q <= xcnt_q;
        xcnt_q <= xcnt_q + 1'b1;
        vmap_q <= lnk_valid_i;
        idx_q  <= '0;
        busy_q <= 1'b1;
        ovf_q  <= busy_q && (idx_q != LAST_IDX);
      end else if (busy_q) begin
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_LINKS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q[g] <= '0;
      else if (xing_i) slot_q[g] <= lnk_valid_i[g] ? lnk_data_i[g*WORD_W +: WORD_W] : '0;
    end
  end

  always_comb begin
    word_mux = '0;
    if (idx_q == IDX_W'(0)) word_mux = ALIGN_WORD[WORD_W-1:0];
    if (idx_q == IDX_W'(1)) word_mux = xnum_q;
    if (idx_q == IDX_W'(2)) word_mux = {{(WORD_W-N_LINKS){1'b0}}, vmap_q};
    for (int i = 0; i < N_LINKS; i++)
      if (idx_q == IDX_W'(HDR_WORDS + i)) word_mux = slot_q[i];
  end

  assign frm_word_o  = busy_q ? word_mux : '0;
  assign frm_valid_o = busy_q;
  assign frm_sof_o   = busy_q && (idx_q == '0);
  assign overflow_o  = ovf_q;

endmodule

module trig_frame_builder_chk #(
  parameter logic [15:0] ALIGN_WORD = 16'hBC1C
) (
  input logic        clk,
  input logic        rst_n,
  input logic        xing_i,
  input logic [15:0] frm_word_o,
  input logic        frm_valid_o,
  input logic        frm_sof_o,
  input logic        overflow_o
);

  // R2
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_sof_o |-> frm_valid_o);

  // R2
  start_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xing_i |=> frm_sof_o);

  // R2
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_o && !frm_sof_o) |-> $past(frm_valid_o));

  // R3
  marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_sof_o |-> (frm_word_o == ALIGN_WORD));

  // R8
  overflow_at_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> frm_sof_o);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid_o |-> (frm_word_o == 16'h0000 && !overflow_o));

endmodule

bind trig_frame_builder trig_frame_builder_chk #(.ALIGN_WORD(ALIGN_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .frm_word_o(frm_word_o),
  .frm_valid_o(frm_valid_o), .frm_sof_o(frm_sof_o), .overflow_o(overflow_o));

// File: tb/trig_frame_builder_tb.sv
`timescale 1ns/1ps
module trig_frame_builder_tb;
  localparam int NL = 6;
  localparam int FL = 3 + NL;
  localparam logic [15:0] MARK = 16'hBC1C;

  logic clk = 1'b0, rst_n = 1'b0, xing_i = 1'b0;
  logic [NL*16-1:0] lnk_data_i = '0;
  logic [NL-1:0] lnk_valid_i = '0;
  logic [15:0] frm_word_o;
  logic frm_valid_o, frm_sof_o, overflow_o;

  int checks = 0, errors = 0;
  logic [15:0] xexp = 16'h0000;

  always #2.5 clk = ~clk;

  trig_frame_builder u_dut (
    .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .lnk_data_i(lnk_data_i),
    .lnk_valid_i(lnk_valid_i), .frm_word_o(frm_word_o), .frm_valid_o(frm_valid_o),
    .frm_sof_o(frm_sof_o), .overflow_o(overflow_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(int k, logic [15:0] num, logic [NL-1:0] vm,
                                           logic [NL*16-1:0] dd);
    if (k == 0) return MARK;
    if (k == 1) return num;
    if (k == 2) return {{(16-NL){1'b0}}, vm};
    return vm[k-3] ? dd[(k-3)*16 +: 16] : 16'h0000;
  endfunction

  // Issue one strobe with the given inputs, then check the whole frame.
  task automatic send_frame(input string req, input logic [NL-1:0] vm,
                            input logic [NL*16-1:0] dd, input bit scramble);
    logic [15:0] num;
    num = xexp;
    @(negedge clk);
    lnk_valid_i = vm; lnk_data_i = dd; xing_i = 1'b1;
    @(negedge clk);
    xing_i = 1'b0;
    xexp = xexp + 16'd1;
    for (int k = 0; k < FL; k++) begin
      if (scramble) begin
        lnk_data_i = ~dd ^ {NL{16'(k * 16'h1111)}};
        lnk_valid_i = ~vm;
      end
      chk({req, " word"}, frm_word_o, exp_word(k, num, vm, dd));
      chk({req, " valid"}, frm_valid_o, 1'b1);
      chk({req, " sof"}, frm_sof_o, k == 0);
      chk({req, " ovf"}, overflow_o, 1'b0);
      @(negedge clk);
    end
    chk({req, " end idle"}, {frm_valid_o, frm_word_o}, 17'h0);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", frm_valid_o, 1'b0);
    chk("R1 reset ovf", overflow_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle word", frm_word_o, 16'h0);
    chk("R1 idle sof", frm_sof_o, 1'b0);
  endtask

  task automatic t_basic;
    send_frame("R1 R2 R3 R4 R5 R6 first", 6'b111111,
               {16'hF005, 16'hE004, 16'hD003, 16'hC002, 16'hB001, 16'hA000}, 1'b0);
    send_frame("R2 R4 R6 second", 6'b111111,
               {16'h0001, 16'h0203, 16'h0405, 16'h0607, 16'h0809, 16'h0A0B}, 1'b0);
  endtask

  task automatic t_partial;
    send_frame("R5 R7 sparse", 6'b100101,
               {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666}, 1'b0);
    send_frame("R5 R7 none", 6'b000000, {NL{16'hFFFF}}, 1'b0);
  endtask

  task automatic t_stable;
    send_frame("R10 scrambled", 6'b011010,
               {16'h9A9A, 16'h8B8B, 16'h7C7C, 16'h6D6D, 16'h5E5E, 16'h4F4F}, 1'b1);
  endtask

  task automatic t_backtoback;
    logic [NL*16-1:0] d1, d2;
    logic [15:0] n1;
    d1 = {16'h0106, 16'h0105, 16'h0104, 16'h0103, 16'h0102, 16'h0101};
    d2 = {16'h0206, 16'h0205, 16'h0204, 16'h0203, 16'h0202, 16'h0201};
    n1 = xexp;
    @(negedge clk);
    lnk_valid_i = '1; lnk_data_i = d1; xing_i = 1'b1;
    @(negedge clk);
    xing_i = 1'b0;
    for (int k = 0; k < FL; k++) begin
      chk("R9 first frame word", frm_word_o, exp_word(k, n1, '1, d1));
      if (k == FL - 1) begin lnk_data_i = d2; xing_i = 1'b1; end
      @(negedge clk);
    end
    xing_i = 1'b0;
    for (int k = 0; k < FL; k++) begin
      chk("R9 next frame word", frm_word_o, exp_word(k, n1 + 16'd1, '1, d2));
      chk("R9 no overflow", overflow_o, 1'b0);
      chk("R9 valid", frm_valid_o, 1'b1);
      @(negedge clk);
    end
    chk("R9 end idle", frm_valid_o, 1'b0);
    xexp = n1 + 16'd2;
  endtask

  task automatic t_overflow;
    logic [NL*16-1:0] d1, d2;
    logic [15:0] n1;
    d1 = {NL{16'h7777}};
    d2 = {16'hC6C6, 16'hC5C5, 16'hC4C4, 16'hC3C3, 16'hC2C2, 16'hC1C1};
    n1 = xexp;
    @(negedge clk);
    lnk_valid_i = '1; lnk_data_i = d1; xing_i = 1'b1;
    @(negedge clk);
    xing_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pre-cut word", frm_word_o, exp_word(3, n1, '1, d1));
    lnk_valid_i = 6'b010011; lnk_data_i = d2; xing_i = 1'b1;
    @(negedge clk);
    xing_i = 1'b0;
    chk("R8 overflow pulse", overflow_o, 1'b1);
    chk("R8 new sof", frm_sof_o, 1'b1);
    for (int k = 0; k < FL; k++) begin
      chk("R8 new frame word", frm_word_o, exp_word(k, n1 + 16'd1, 6'b010011, d2));
      if (k > 0) chk("R8 overflow one cycle", overflow_o, 1'b0);
      @(negedge clk);
    end
    chk("R8 end idle", frm_valid_o, 1'b0);
    xexp = n1 + 16'd2;
  endtask

  task automatic t_wrap;
    int m;
    m = 65535 - int'(xexp);
    @(negedge clk);
    lnk_valid_i = '0; xing_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 continuous strobe overflow", overflow_o, 1'b1);
    repeat (m - 2) @(negedge clk);
    xing_i = 1'b0;
    xexp = 16'hFFFF;
    repeat (FL + 2) @(negedge clk);
    send_frame("R4 number FFFF", 6'b000001, {NL{16'h0F0F}}, 1'b0);
    send_frame("R4 wrap to 0", 6'b000010, {NL{16'hF0F0}}, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_partial();
    t_stable();
    t_backtoback();
    t_overflow();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule